// File: doc/BRIEF.md
# Per-CPU Interrupt Presenter

This block sits between the interrupt sources of a system and one processor. It holds at most one pending interrupt for that processor and drives the processor's interrupt line while that interrupt is held. Sources offer requests that carry a source number and a priority. A numerically smaller priority is more favoured, and the all-ones priority means "none". Each request is either taken into the single slot or returned to its source at once through a reject strobe. When a more favoured request takes the slot from an external source, that source is rejected. A software-written inter-processor interrupt (IPI) priority competes for the same slot under the fixed source number 2.

Software works on a 32-bit presentation word. Bits 31:24 hold the current processor priority and bits 23:0 hold the pending source number, where zero means nothing is pending. Software can accept, poll, set the processor priority, set the IPI priority and signal end-of-interrupt. Toward the sources the block returns exactly one kind of strobe per cycle: a reject with a source number, an end-of-interrupt with a source number, or a resend request that asks every source to offer again. An operation is sampled on a rising clock edge, and its read data, line level and strobe are visible after that same edge.

Top module: `ipres_top`

## Requirements
- R1: After reset the processor priority is 0x00, no source is pending, the pending priority and the IPI priority are 0xFF, the interrupt line is low, and no strobe or read data is valid.
- R2: A request is rejected, with a reject strobe carrying its own source number, when its priority is not below the processor priority or when a held source already has a priority less than or equal to it.
- R3: A request that is not rejected is latched with its priority, and the line is raised. A held external source that it displaces gets a reject strobe in the same cycle. A displaced IPI gets no strobe.
- R4: Op code 0 (accept) returns the word {processor priority, source} and lowers the line. It loads the processor priority from the pending priority, clears the source and sets the pending priority to 0xFF.
- R5: Op code 1 (poll) returns the word and the IPI priority and changes no state.
- R6: Op code 3 writes the IPI priority from op_data[7:0]. If the new value is below the processor priority and no held source has a priority less than or equal to it, source 2 is presented at that priority and the line is raised. A displaced external source is rejected.
- R7: Op code 2 writes the processor priority from op_data[7:0]. When the value drops and a held source has a priority greater than or equal to the new value, that source is dropped and the line is lowered. A dropped external source is rejected.
- R8: When op code 2 leaves the processor priority equal or higher and nothing is held, the IPI is checked against the new priority and a resend strobe is requested.
- R9: Op code 4 (end-of-interrupt) loads the processor priority from op_data[31:24] and sends an end-of-interrupt strobe carrying op_data[23:0]. If nothing is then held, the IPI is checked and a resend is requested.
- R10: At most one strobe is valid per cycle. A requested resend goes out in the first cycle that has no reject or end-of-interrupt strobe, including the cycle of the request itself.
- R11: A request presented in the same cycle as an operation is ignored and gets no strobe. Op codes 5 to 7 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Source request present |
| req_src | input | 24 | Requesting source number |
| req_prio | input | 8 | Requested priority |
| op_valid | input | 1 | Software operation present |
| op_code | input | 3 | Operation: 0 accept, 1 poll, 2 set priority, 3 set IPI priority, 4 end-of-interrupt |
| op_data | input | 32 | Operation data |
| rd_valid | output | 1 | Read data valid after accept or poll |
| rd_word | output | 32 | Presentation word {priority, source} |
| rd_ipi_prio | output | 8 | IPI priority |
| irq_out | output | 1 | Interrupt line to the processor |
| rej_valid | output | 1 | Reject strobe |
| rej_src | output | 24 | Rejected source number |
| eoi_valid | output | 1 | End-of-interrupt strobe |
| eoi_src | output | 24 | Source number being completed |
| resend_valid | output | 1 | Resend request strobe |

## Verification
The admission rule is exercised with requests that fall below the processor priority, requests that tie with the held priority, and requests that beat either an external source or an IPI. These cases show whether a reject goes to the newcomer, to the displaced owner, or to nobody. IPI writes are tried both above and below a held priority. Priority writes cover a drop that removes the held source, a rise that triggers a resend, and a rise that brings in a waiting IPI. End-of-interrupt is issued both with and without a following request, which shows whether the resend waits for a free strobe cycle.

// File: rtl/ipres_pkg.sv
package ipres_pkg;

    typedef enum logic [2:0] {
        OP_ACCEPT   = 3'd0,
        OP_POLL     = 3'd1,
        OP_SET_CPPR = 3'd2,
        OP_SET_IPI  = 3'd3,
        OP_EOI      = 3'd4
    } op_e;

    typedef enum logic [1:0] {
        EV_NONE   = 2'd0,
        EV_REJECT = 2'd1,
        EV_EOI    = 2'd2,
        EV_RESEND = 2'd3
    } ev_e;

endpackage

// File: rtl/ipres_judge.sv
// Decides whether a candidate may take the single pending slot.
module ipres_judge #(
    parameter int unsigned PRIO_W = 8
) (
    input  logic [PRIO_W-1:0] cand_prio,
    input  logic [PRIO_W-1:0] cppr,
    input  logic              pend_valid,
    input  logic [PRIO_W-1:0] pend_prio,
    output logic              win
);
    always_comb begin
        win = (cand_prio < cppr) && !(pend_valid && (pend_prio <= cand_prio));
    end
endmodule

// File: rtl/ipres_strobe.sv
// Source-side strobe register with a deferred resend.
module ipres_strobe
    import ipres_pkg::*;
#(
    parameter int unsigned SRC_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  ev_e              ev_kind,
    input  logic [SRC_W-1:0] ev_src,
    input  logic             resend_req,
    output logic             rej_valid,
    output logic [SRC_W-1:0] rej_src,
    output logic             eoi_valid,
    output logic [SRC_W-1:0] eoi_src,
    output logic             resend_valid
);
    typedef struct packed {
        ev_e              kind;
        logic [SRC_W-1:0] src;
        logic             pend;
    } sb_t;

    sb_t sb_d, sb_q;

    always_comb begin
        sb_d = sb_q;
        if (ev_kind != EV_NONE) begin
            sb_d.kind = ev_kind;
            sb_d.src  = ev_src;
            sb_d.pend = sb_q.pend | resend_req;
        end else if (sb_q.pend || resend_req) begin
            sb_d.kind = EV_RESEND;
            sb_d.src  = '0;
            sb_d.pend = 1'b0;
        end else begin
            sb_d.kind = EV_NONE;
            sb_d.src  = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sb_q <= '{kind: EV_NONE, src: '0, pend: 1'b0};
        end else begin
            sb_q <= sb_d;
        end
    end

    assign rej_valid    = (sb_q.kind == EV_REJECT);
    assign eoi_valid    = (sb_q.kind == EV_EOI);
    assign resend_valid = (sb_q.kind == EV_RESEND);
    assign rej_src      = sb_q.src;
    assign eoi_src      = sb_q.src;

    // A resend that was held back must show up as soon as no other strobe is due
    AST_RESEND_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        (sb_q.pend && ev_kind == EV_NONE) |=> resend_valid); // R10

endmodule

// File: rtl/ipres_top.sv
module ipres_top
    import ipres_pkg::*;
#(
    parameter int unsigned SRC_W   = 24,
    parameter int unsigned PRIO_W  = 8,
    parameter int unsigned IPI_SRC = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    req_valid,
    input  logic [SRC_W-1:0]        req_src,
    input  logic [PRIO_W-1:0]       req_prio,
    input  logic                    op_valid,
    input  logic [2:0]              op_code,
    input  logic [SRC_W+PRIO_W-1:0] op_data,
    output logic                    rd_valid,
    output logic [SRC_W+PRIO_W-1:0] rd_word,
    output logic [PRIO_W-1:0]       rd_ipi_prio,
    output logic                    irq_out,
    output logic                    rej_valid,
    output logic [SRC_W-1:0]        rej_src,
    output logic                    eoi_valid,
    output logic [SRC_W-1:0]        eoi_src,
    output logic                    resend_valid
);
    localparam int unsigned WORD_W    = SRC_W + PRIO_W;
    localparam int unsigned N_CAND    = 2;   // 0: source request, 1: IPI
    localparam logic [PRIO_W-1:0] PRIO_NONE = {PRIO_W{1'b1}};
    localparam logic [SRC_W-1:0]  IPI_NUM   = SRC_W'(IPI_SRC);

    typedef struct packed {
        logic [PRIO_W-1:0] cppr;
        logic [SRC_W-1:0]  xsrc;
        logic [PRIO_W-1:0] pprio;
        logic [PRIO_W-1:0] ipi_prio;
        logic              ext;      // held source came from outside (not the IPI)
        logic              irq;
        logic              rd_v;
        logic [WORD_W-1:0] rd_w;
        logic [PRIO_W-1:0] rd_m;
    } st_t;

    st_t st_d, st_q;

    logic [PRIO_W-1:0] cand_prio  [N_CAND];
    logic [PRIO_W-1:0] judge_cppr [N_CAND];
    logic [N_CAND-1:0] win;
    logic              pend;
    logic              ipi_fire;
    ev_e               ev_kind;
    logic [SRC_W-1:0]  ev_src;
    logic              resend_req;
    logic [PRIO_W-1:0] op_lo;

    assign pend  = (st_q.xsrc != '0);
    assign op_lo = op_data[PRIO_W-1:0];

    // Candidate priorities and the processor priority each is judged against
    always_comb begin
        cand_prio[0]  = req_prio;
        judge_cppr[0] = st_q.cppr;
        cand_prio[1]  = st_q.ipi_prio;
        judge_cppr[1] = st_q.cppr;
        if (op_valid) begin
            case (op_code)
                OP_SET_IPI:  cand_prio[1]  = op_lo;
                OP_SET_CPPR: judge_cppr[1] = op_lo;
                OP_EOI:      judge_cppr[1] = op_data[WORD_W-1 -: PRIO_W];
                default:     ;
            endcase
        end
    end

    for (genvar g = 0; g < N_CAND; g++) begin : g_judge
        ipres_judge #(
            .PRIO_W (PRIO_W)
        ) i_judge (
            .cand_prio  (cand_prio[g]),
            .cppr       (judge_cppr[g]),
            .pend_valid (pend),
            .pend_prio  (st_q.pprio),
            .win        (win[g])
        );
    end

    always_comb begin
        st_d       = st_q;
        st_d.rd_v  = 1'b0;
        ev_kind    = EV_NONE;
        ev_src     = '0;
        resend_req = 1'b0;
        ipi_fire   = 1'b0;

        if (op_valid) begin
            case (op_code)
                OP_ACCEPT: begin
                    st_d.rd_v  = 1'b1;
                    st_d.rd_w  = {st_q.cppr, st_q.xsrc};
                    st_d.rd_m  = st_q.ipi_prio;
                    st_d.irq   = 1'b0;
                    st_d.cppr  = st_q.pprio;
                    st_d.xsrc  = '0;
                    st_d.pprio = PRIO_NONE;
                    st_d.ext   = 1'b0;
                end
                OP_POLL: begin
                    st_d.rd_v = 1'b1;
                    st_d.rd_w = {st_q.cppr, st_q.xsrc};
                    st_d.rd_m = st_q.ipi_prio;
                end
                OP_SET_CPPR: begin
                    st_d.cppr = op_lo;
                    if (op_lo < st_q.cppr) begin
                        if (pend && (op_lo <= st_q.pprio)) begin
                            st_d.xsrc  = '0;
                            st_d.pprio = PRIO_NONE;
                            st_d.irq   = 1'b0;
                            st_d.ext   = 1'b0;
                            if (st_q.ext) begin
                                ev_kind = EV_REJECT;
                                ev_src  = st_q.xsrc;
                            end
                        end
                    end else if (!pend) begin
                        resend_req = 1'b1;
                        ipi_fire   = win[1];
                    end
                end
                OP_SET_IPI: begin
                    st_d.ipi_prio = op_lo;
                    ipi_fire      = win[1];
                end
                OP_EOI: begin
                    st_d.cppr = op_data[WORD_W-1 -: PRIO_W];
                    ev_kind   = EV_EOI;
                    ev_src    = op_data[SRC_W-1:0];
                    if (!pend) begin
                        resend_req = 1'b1;
                        ipi_fire   = win[1];
                    end
                end
                default: ;
            endcase

            if (ipi_fire) begin
                if (pend && st_q.ext) begin
                    ev_kind = EV_REJECT;
                    ev_src  = st_q.xsrc;
                end
                st_d.xsrc  = IPI_NUM;
                st_d.pprio = cand_prio[1];
                st_d.ext   = 1'b0;
                st_d.irq   = 1'b1;
            end
        end else if (req_valid) begin
            if (!win[0]) begin
                ev_kind = EV_REJECT;
                ev_src  = req_src;
            end else begin
                if (pend && st_q.ext) begin
                    ev_kind = EV_REJECT;
                    ev_src  = st_q.xsrc;
                end
                st_d.xsrc  = req_src;
                st_d.pprio = req_prio;
                st_d.ext   = 1'b1;
                st_d.irq   = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{cppr: '0, xsrc: '0, pprio: PRIO_NONE, ipi_prio: PRIO_NONE,
                      ext: 1'b0, irq: 1'b0, rd_v: 1'b0, rd_w: '0, rd_m: '0};
        end else begin
            st_q <= st_d;
        end
    end

    ipres_strobe #(
        .SRC_W (SRC_W)
    ) i_strobe (
        .clk          (clk),
        .rst_n        (rst_n),
        .ev_kind      (ev_kind),
        .ev_src       (ev_src),
        .resend_req   (resend_req),
        .rej_valid    (rej_valid),
        .rej_src      (rej_src),
        .eoi_valid    (eoi_valid),
        .eoi_src      (eoi_src),
        .resend_valid (resend_valid)
    );

    assign rd_valid    = st_q.rd_v;
    assign rd_word     = st_q.rd_w;
    assign rd_ipi_prio = st_q.rd_m;
    assign irq_out     = st_q.irq;

    AST_LINE_TRACKS_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out == (st_q.xsrc != '0)); // R3

    AST_WEAK_REQ_REJECTED: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !op_valid && req_prio >= st_q.cppr)
        |=> (rej_valid && rej_src == $past(req_src))); // R2

    AST_ACCEPT_DROPS_LINE: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == OP_ACCEPT) |=> (!irq_out && rd_valid)); // R4

    AST_POLL_KEEPS_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == OP_POLL)
        |=> ($stable(st_q.cppr) && $stable(st_q.xsrc) && $stable(st_q.pprio)
             && $stable(st_q.ipi_prio) && $stable(irq_out))); // R5

    AST_EOI_FORWARDED: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == OP_EOI)
        |=> (eoi_valid && eoi_src == $past(op_data[SRC_W-1:0]))); // R9

endmodule

// File: tb/test_ipres_top.sv
module test_ipres_top;
    localparam time CLK_PERIOD = 10ns;
    localparam int  NVEC       = 21;

    typedef struct packed {
        logic        is_op;
        logic [2:0]  code;
        logic [31:0] data;
        logic [23:0] rsrc;
        logic [7:0]  rprio;
        logic        e_irq;
        logic [1:0]  e_ev;     // 0 none, 1 reject, 2 eoi, 3 resend
        logic [23:0] e_src;
        logic        e_rd;
        logic [31:0] e_word;
        logic [7:0]  e_m;
        logic [31:0] tag;
    } vec_t;

    localparam vec_t VEC [NVEC] = '{
        '{1'b0, 3'd0, 32'h0,        24'h10, 8'h05, 1'b0, 2'd1, 24'h10, 1'b0, 32'h0,        8'h00, "R2"},
        '{1'b1, 3'd2, 32'h000000FF, 24'h0,  8'h00, 1'b0, 2'd3, 24'h0,  1'b0, 32'h0,        8'h00, "R8"},
        '{1'b1, 3'd1, 32'h0,        24'h0,  8'h00, 1'b0, 2'd0, 24'h0,  1'b1, 32'hFF000000, 8'hFF, "R5"},
        '{1'b0, 3'd0, 32'h0,        24'h10, 8'h05, 1'b1, 2'd0, 24'h0,  1'b0, 32'h0,        8'h00, "R3"},
        '{1'b0, 3'd0, 32'h0,        24'h20, 8'h05, 1'b1, 2'd1, 24'h20, 1'b0, 32'h0,        8'h00, "R2"},
        '{1'b0, 3'd0, 32'h0,        24'h30, 8'h03, 1'b1, 2'd1, 24'h10, 1'b0, 32'h0,        8'h00, "R3"},
        '{1'b1, 3'd1, 32'h0,        24'h0,  8'h00, 1'b1, 2'd0, 24'h0,  1'b1, 32'hFF000030, 8'hFF, "R5"},
        '{1'b1, 3'd3, 32'h00000004, 24'h0,  8'h00, 1'b1, 2'd0, 24'h0,  1'b0, 32'h0,        8'h00, "R6"},
        '{1'b1, 3'd3, 32'h00000001, 24'h0,  8'h00, 1'b1, 2'd1, 24'h30, 1'b0, 32'h0,        8'h00, "R6"},
        '{1'b1, 3'd1, 32'h0,        24'h0,  8'h00, 1'b1, 2'd0, 24'h0,  1'b1, 32'hFF000002, 8'h01, "R6"},
        '{1'b0, 3'd0, 32'h0,        24'h40, 8'h00, 1'b1, 2'd0, 24'h0,  1'b0, 32'h0,        8'h00, "R3"},
        '{1'b1, 3'd0, 32'h0,        24'h0,  8'h00, 1'b0, 2'd0, 24'h0,  1'b1, 32'hFF000040, 8'h01, "R4"},
        '{1'b1, 3'd1, 32'h0,        24'h0,  8'h00, 1'b0, 2'd0, 24'h0,  1'b1, 32'h00000000, 8'h01, "R4"},
        '{1'b1, 3'd4, 32'hFF000040, 24'h0,  8'h00, 1'b1, 2'd2, 24'h40, 1'b0, 32'h0,        8'h00, "R9"},
        '{1'b1, 3'd1, 32'h0,        24'h0,  8'h00, 1'b1, 2'd3, 24'h0,  1'b1, 32'hFF000002, 8'h01, "R10"},
        '{1'b1, 3'd2, 32'h00000001, 24'h0,  8'h00, 1'b0, 2'd0, 24'h0,  1'b0, 32'h0,        8'h00, "R7"},
        '{1'b1, 3'd1, 32'h0,        24'h0,  8'h00, 1'b0, 2'd0, 24'h0,  1'b1, 32'h01000000, 8'h01, "R7"},
        '{1'b1, 3'd2, 32'h00000008, 24'h0,  8'h00, 1'b1, 2'd3, 24'h0,  1'b0, 32'h0,        8'h00, "R8"},
        '{1'b0, 3'd0, 32'h0,        24'h50, 8'h00, 1'b1, 2'd0, 24'h0,  1'b0, 32'h0,        8'h00, "R3"},
        '{1'b1, 3'd2, 32'h00000000, 24'h0,  8'h00, 1'b0, 2'd1, 24'h50, 1'b0, 32'h0,        8'h00, "R7"},
        '{1'b1, 3'd1, 32'h0,        24'h0,  8'h00, 1'b0, 2'd0, 24'h0,  1'b1, 32'h00000000, 8'h01, "R7"}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [23:0] req_src = '0;
    logic [7:0]  req_prio = '0;
    logic        op_valid = 1'b0;
    logic [2:0]  op_code = '0;
    logic [31:0] op_data = '0;
    logic        rd_valid;
    logic [31:0] rd_word;
    logic [7:0]  rd_ipi_prio;
    logic        irq_out;
    logic        rej_valid;
    logic [23:0] rej_src;
    logic        eoi_valid;
    logic [23:0] eoi_src;
    logic        resend_valid;

    int n_run  = 0;
    int n_fail = 0;
    logic done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ipres_top i_ipres_top (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_valid    (req_valid),
        .req_src      (req_src),
        .req_prio     (req_prio),
        .op_valid     (op_valid),
        .op_code      (op_code),
        .op_data      (op_data),
        .rd_valid     (rd_valid),
        .rd_word      (rd_word),
        .rd_ipi_prio  (rd_ipi_prio),
        .irq_out      (irq_out),
        .rej_valid    (rej_valid),
        .rej_src      (rej_src),
        .eoi_valid    (eoi_valid),
        .eoi_src      (eoi_src),
        .resend_valid (resend_valid)
    );

    task automatic chk(input logic [31:0] tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // Drive one cycle of stimulus at the falling edge; outputs settle after the next rising edge
    task automatic drive(input logic ov, input logic [2:0] code, input logic [31:0] data,
                         input logic rv, input logic [23:0] rs, input logic [7:0] rp);
        @(negedge clk);
        op_valid  = ov;
        op_code   = code;
        op_data   = data;
        req_valid = rv;
        req_src   = rs;
        req_prio  = rp;
        @(posedge clk);
        #1;
    endtask

    task automatic idle();
        @(negedge clk);
        op_valid  = 1'b0;
        req_valid = 1'b0;
    endtask

    task automatic expect_out(input logic [31:0] tag, input logic e_irq, input logic [1:0] e_ev,
                              input logic [23:0] e_src, input logic e_rd,
                              input logic [31:0] e_word, input logic [7:0] e_m);
        logic [1:0] act_ev;
        act_ev = rej_valid ? 2'd1 : eoi_valid ? 2'd2 : resend_valid ? 2'd3 : 2'd0;
        chk(tag, "irq_out", 32'(irq_out), 32'(e_irq));
        chk(tag, "strobe kind", 32'(act_ev), 32'(e_ev));
        chk("R10", "strobe count", 32'(int'(rej_valid) + int'(eoi_valid) + int'(resend_valid)),
            (e_ev == 2'd0) ? 32'd0 : 32'd1);
        if (e_ev == 2'd1) chk(tag, "rej_src", 32'(rej_src), 32'(e_src));
        if (e_ev == 2'd2) chk(tag, "eoi_src", 32'(eoi_src), 32'(e_src));
        chk(tag, "rd_valid", 32'(rd_valid), 32'(e_rd));
        if (e_rd) begin
            chk(tag, "rd_word", rd_word, e_word);
            chk(tag, "rd_ipi_prio", 32'(rd_ipi_prio), 32'(e_m));
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n     = 1'b0;
        op_valid  = 1'b0;
        req_valid = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin : main
        do_reset();
        // R1: quiet outputs right after reset, then a poll shows the reset word
        #1;
        expect_out("R1", 1'b0, 2'd0, 24'h0, 1'b0, 32'h0, 8'h0);
        drive(1'b1, 3'd1, 32'h0, 1'b0, 24'h0, 8'h0);
        expect_out("R1", 1'b0, 2'd0, 24'h0, 1'b1, 32'h00000000, 8'hFF);

        for (int i = 0; i < NVEC; i++) begin
            drive(VEC[i].is_op, VEC[i].code, VEC[i].data,
                  !VEC[i].is_op, VEC[i].rsrc, VEC[i].rprio);
            expect_out(VEC[i].tag, VEC[i].e_irq, VEC[i].e_ev, VEC[i].e_src,
                       VEC[i].e_rd, VEC[i].e_word, VEC[i].e_m);
        end
        idle();

        // Resend held back behind a reject, then released on a no-op cycle
        do_reset();
        drive(1'b1, 3'd2, 32'h00000080, 1'b0, 24'h0, 8'h0);
        expect_out("R8", 1'b0, 2'd3, 24'h0, 1'b0, 32'h0, 8'h0);
        drive(1'b1, 3'd4, 32'h80000007, 1'b0, 24'h0, 8'h0);
        expect_out("R9", 1'b0, 2'd2, 24'h7, 1'b0, 32'h0, 8'h0);
        drive(1'b0, 3'd0, 32'h0, 1'b1, 24'h9, 8'h90);
        expect_out("R10", 1'b0, 2'd1, 24'h9, 1'b0, 32'h0, 8'h0);
        // r11_ undefined op code: no state change, deferred resend goes out
        drive(1'b1, 3'd7, 32'hFFFFFFFF, 1'b0, 24'h0, 8'h0);
        expect_out("R10", 1'b0, 2'd3, 24'h0, 1'b0, 32'h0, 8'h0);
        // R11: request alongside a poll is ignored
        drive(1'b1, 3'd1, 32'h0, 1'b1, 24'h11, 8'h00);
        expect_out("R11", 1'b0, 2'd0, 24'h0, 1'b1, 32'h80000000, 8'hFF);
        drive(1'b1, 3'd1, 32'h0, 1'b0, 24'h0, 8'h0);
        expect_out("R11", 1'b0, 2'd0, 24'h0, 1'b1, 32'h80000000, 8'hFF);
        // R2 corner: priority 0xFF is never admitted
        drive(1'b1, 3'd2, 32'h000000FF, 1'b0, 24'h0, 8'h0);
        expect_out("R8", 1'b0, 2'd3, 24'h0, 1'b0, 32'h0, 8'h0);
        drive(1'b0, 3'd0, 32'h0, 1'b1, 24'h12, 8'hFF);
        expect_out("R2", 1'b0, 2'd1, 24'h12, 1'b0, 32'h0, 8'h0);
        idle();

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule